// File: doc/BRIEF.md
# Receive Buffer Resource Ring Manager

This block keeps track of the circular table of receive-buffer descriptors that a network receiver draws its buffer space from. Software programs a start, an end, a read and a write pointer (16 bits each, together with a shared upper address half). On request, the block walks to the entry under the read pointer, reads its four 16-bit words over a request/response memory port, and latches a 32-bit buffer address and a 32-bit remaining word count. It then moves the read pointer one entry forward, wrapping at the end pointer, and flags when the entry just taken was the last one that software had made available.

While frames arrive, the block charges each frame's padded length against the current buffer. It moves the buffer address forward, lowers the remaining word count and raises a last-packet flag when the buffer becomes too small. After such a frame it either fetches the next entry on its own or, if no entry is left, stalls reception until software frees one. The frame data itself is moved elsewhere. This block only does the bookkeeping of buffer space. A data-width mode selects 16-bit or 32-bit descriptor layout and pointer alignment.

Top module: `rx_rsrc_ring`

## Requirements
- R1: After reset the read pointer, buffer address, buffer word count and status are zero, stall and last-packet are low, no memory request is pending and frames are accepted (frame_ready high).
- R2: A fetch issues four word reads, one outstanding at a time, at {upper, read pointer + k*scale} for k = 0..3, where scale is 2 bytes in 16-bit mode and 4 bytes in 32-bit mode. Word 0 is the buffer address low half, word 1 the address high half, word 2 the word count low half and word 3 the word count high half.
- R3: After a fetch the read pointer advances by 8 bytes (16-bit mode) or 16 bytes (32-bit mode). If the advanced value equals the end pointer, it is reloaded from the start pointer.
- R4: If the read pointer equals the write pointer after the advance, status bit 5 (exhausted) is set.
- R5: Pointer writes (cfg_sel 0 start, 1 end, 2 read, 3 write) are masked with 0xFFFE in 16-bit mode and 0xFFFC in 32-bit mode. cfg_sel 4 writes the upper address half and cfg_sel 5 the end-of-buffer threshold (reset value 0x02F8).
- R6: A write-one-to-clear of status bit 5 while it is set starts a new fetch. A write-one-to-clear of a bit that is already clear starts no fetch.
- R7: An accepted frame of L bytes has padded length P = L+4 rounded up to a multiple of 2 (16-bit mode) or 4 (32-bit mode). The word count drops by P/2 and the buffer address rises by P.
- R8: If P exceeds twice the remaining word count, status bit 4 (buffer exceeded) and last-packet are set, and the word count and buffer address are left unchanged.
- R9: If the word count after a frame is below the threshold, last-packet is set. When last-packet is set and the read pointer differs from the write pointer, the next entry is fetched. Last-packet clears on the next accepted frame that leaves enough space.
- R10: When last-packet is set and the read pointer equals the write pointer, rx_stall rises, frame_ready stays low and offered frames are ignored. rx_stall clears when the next fetch completes.
- R11: A memory request that is not yet accepted keeps its valid and address stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1 = 32-bit descriptor layout, 0 = 16-bit |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target (R5 encoding) |
| cfg_wdata | input | 16 | Configuration write data |
| fetch_req | input | 1 | Request to fetch the next ring entry |
| sts_clr | input | 1 | Status write-one-to-clear strobe |
| sts_clr_mask | input | 16 | Status bits to clear |
| frame_valid | input | 1 | A received frame is offered |
| frame_len | input | 16 | Frame length in bytes |
| frame_ready | output | 1 | Frame is taken this cycle if valid |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 16 | Read data word |
| rd_ptr | output | 16 | Current read pointer |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Remaining buffer word count |
| status | output | 16 | Status: bit 4 exceeded, bit 5 exhausted |
| last_pkt | output | 1 | Buffer holds no room for another frame |
| rx_stall | output | 1 | Reception stalled for lack of entries |
| busy | output | 1 | A fetch is pending or in progress |

## Verification
A wrong entry offset or stride shows on the memory address bus within the fetch itself, and a bad wrap shows on rd_ptr one cycle after the fourth response. A corrupted word count or padding rule shows on buf_words in the cycle after the frame is taken. A missed stall or exhaustion decision shows either as frame_ready staying high with no entries left, or as a fetch to an entry software never released. The directed cases sit on the exact boundaries: a count landing one word under the threshold, a read pointer landing on the end pointer, and a padded length just above the remaining space.

// File: rtl/rx_rsrc_ring_pkg.sv
package rx_rsrc_ring_pkg;

   localparam int ENTRY_WORDS = 4;

   typedef enum logic [1:0] {
      F_IDLE = 2'd0,
      F_REQ  = 2'd1,
      F_WAIT = 2'd2,
      F_DONE = 2'd3
   } fetch_state_t;

   localparam logic [2:0] CFG_START  = 3'd0;
   localparam logic [2:0] CFG_END    = 3'd1;
   localparam logic [2:0] CFG_READ   = 3'd2;
   localparam logic [2:0] CFG_WRITE  = 3'd3;
   localparam logic [2:0] CFG_UPPER  = 3'd4;
   localparam logic [2:0] CFG_THRESH = 3'd5;

   localparam int STS_EXCEEDED  = 4;
   localparam int STS_EXHAUSTED = 5;

endpackage

// File: rtl/rx_rsrc_ring_cfg.sv
module rx_rsrc_ring_cfg
   import rx_rsrc_ring_pkg::*;
#(
   parameter int           PTR_W      = 16,
   parameter logic [15:0]  THRESH_RST = 16'h02F8,
   parameter bit           WIDE_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wide_i,
   input  logic             wr_en_i,
   input  logic [2:0]       sel_i,
   input  logic [PTR_W-1:0] wdata_i,
   output logic             wide_o,
   output logic [PTR_W-1:0] start_o,
   output logic [PTR_W-1:0] end_o,
   output logic [PTR_W-1:0] wrp_o,
   output logic [PTR_W-1:0] upper_o,
   output logic [PTR_W-1:0] thresh_o,
   output logic             rd_load_o,
   output logic [PTR_W-1:0] rd_val_o
);

   logic [PTR_W-1:0] align_mask;
   logic [PTR_W-1:0] masked;

   generate
      if (WIDE_EN) begin : g_wide
         assign wide_o = wide_i;
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide_i;
         assign wide_o      = 1'b0;
      end
   endgenerate

   assign align_mask = wide_o ? {{(PTR_W-2){1'b1}}, 2'b00} : {{(PTR_W-1){1'b1}}, 1'b0};
   assign masked     = wdata_i & align_mask;
   assign rd_load_o  = wr_en_i && (sel_i == CFG_READ);
   assign rd_val_o   = masked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o  <= '0;
         end_o    <= '0;
         wrp_o    <= '0;
         upper_o  <= '0;
         thresh_o <= PTR_W'(THRESH_RST);
      end else if (wr_en_i) begin
         case (sel_i)
            CFG_START:  start_o  <= masked;
            CFG_END:    end_o    <= masked;
            CFG_WRITE:  wrp_o    <= masked;
            CFG_UPPER:  upper_o  <= wdata_i;
            CFG_THRESH: thresh_o <= wdata_i;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/rx_rsrc_ring_fetch.sv
module rx_rsrc_ring_fetch
   import rx_rsrc_ring_pkg::*;
#(
   parameter int PTR_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    wide_i,
   input  logic [PTR_W-1:0]                        start_i,
   input  logic [PTR_W-1:0]                        end_i,
   input  logic [PTR_W-1:0]                        wrp_i,
   input  logic [PTR_W-1:0]                        upper_i,
   input  logic                                    rd_load_i,
   input  logic [PTR_W-1:0]                        rd_val_i,
   input  logic                                    go_i,
   output logic                                    mem_req_valid_o,
   input  logic                                    mem_req_ready_i,
   output logic [2*PTR_W-1:0]                      mem_req_addr_o,
   input  logic                                    mem_rsp_valid_i,
   input  logic [DATA_W-1:0]                       mem_rsp_data_i,
   output logic                                    busy_o,
   output logic                                    done_o,
   output logic                                    exhausted_o,
   output logic [PTR_W-1:0]                        rd_ptr_o,
   output logic [ENTRY_WORDS-1:0][DATA_W-1:0]      entry_o
);

   localparam int IDX_W      = $clog2(ENTRY_WORDS);
   localparam int STRIDE_NAR = ENTRY_WORDS * 2;
   localparam int STRIDE_WID = ENTRY_WORDS * 4;

   fetch_state_t                     state_q;
   logic [IDX_W-1:0]                 idx_q;
   logic [PTR_W-1:0]                 rd_q;
   logic [ENTRY_WORDS-1:0][DATA_W-1:0] entry_q;
   logic [PTR_W-1:0]                 word_off;
   logic [PTR_W-1:0]                 rd_adv;
   logic [PTR_W-1:0]                 rd_next;

   always_comb begin
      word_off = wide_i ? PTR_W'({idx_q, 2'b00}) : PTR_W'({idx_q, 1'b0});
      rd_adv   = rd_q + (wide_i ? PTR_W'(STRIDE_WID) : PTR_W'(STRIDE_NAR));
      rd_next  = (rd_adv == end_i) ? start_i : rd_adv;
   end

   assign mem_req_valid_o = (state_q == F_REQ);
   assign mem_req_addr_o  = {upper_i, rd_q + word_off};
   assign busy_o          = (state_q != F_IDLE);
   assign done_o          = (state_q == F_DONE);
   assign exhausted_o     = done_o && (rd_next == wrp_i);
   assign rd_ptr_o        = rd_q;
   assign entry_o         = entry_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= F_IDLE;
         idx_q   <= '0;
         rd_q    <= '0;
         entry_q <= '0;
      end else begin
         if (rd_load_i) rd_q <= rd_val_i;
         case (state_q)
            F_IDLE: if (go_i) begin
               state_q <= F_REQ;
               idx_q   <= '0;
            end
            F_REQ: if (mem_req_ready_i) state_q <= F_WAIT;
            F_WAIT: if (mem_rsp_valid_i) begin
               entry_q[idx_q] <= mem_rsp_data_i;
               if (idx_q == IDX_W'(ENTRY_WORDS - 1)) begin
                  state_q <= F_DONE;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= F_REQ;
               end
            end
            F_DONE: begin
               rd_q    <= rd_next;
               state_q <= F_IDLE;
            end
            default: state_q <= F_IDLE;
         endcase
      end
   end

   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

   p_rd_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr_o[0] == 1'b0);

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (start_i != end_i) && !rd_load_i) |=> (rd_ptr_o != $past(end_i)));

endmodule

// File: rtl/rx_rsrc_ring_space.sv
module rx_rsrc_ring_space #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32,
   parameter int LEN_W  = 16,
   parameter int THR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_i,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic [CNT_W-1:0]  load_cnt_i,
   input  logic              frame_fire_i,
   input  logic [LEN_W-1:0]  frame_len_i,
   input  logic [THR_W-1:0]  thresh_i,
   output logic [ADDR_W-1:0] buf_addr_o,
   output logic [CNT_W-1:0]  buf_words_o,
   output logic              last_pkt_o,
   output logic              exceed_o,
   output logic              need_next_o
);

   localparam int PAD_W = LEN_W + 2;
   localparam int CMP_W = CNT_W + 2;

   logic [PAD_W-1:0]  raw_len;
   logic [PAD_W-1:0]  padded;
   logic              too_big;
   logic [CNT_W-1:0]  words_after;
   logic              below;

   always_comb begin
      raw_len     = PAD_W'(frame_len_i) + PAD_W'(4);
      padded      = wide_i ? ((raw_len + PAD_W'(3)) & ~PAD_W'(3))
                           : ((raw_len + PAD_W'(1)) & ~PAD_W'(1));
      too_big     = CMP_W'(padded) > {1'b0, buf_words_o, 1'b0};
      words_after = buf_words_o - CNT_W'(padded >> 1);
      below       = words_after < CNT_W'(thresh_i);
   end

   assign exceed_o    = frame_fire_i && too_big;
   assign need_next_o = frame_fire_i && (too_big || below);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_addr_o  <= '0;
         buf_words_o <= '0;
         last_pkt_o  <= 1'b0;
      end else if (load_i) begin
         buf_addr_o  <= load_addr_i;
         buf_words_o <= load_cnt_i;
      end else if (frame_fire_i) begin
         last_pkt_o <= too_big || below;
         if (!too_big) begin
            buf_words_o <= words_after;
            buf_addr_o  <= buf_addr_o + ADDR_W'(padded);
         end
      end
   end

   p_words_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_fire_i && !load_i) |=> (buf_words_o <= $past(buf_words_o)));

endmodule

// File: rtl/rx_rsrc_ring.sv
module rx_rsrc_ring
   import rx_rsrc_ring_pkg::*;
#(
   parameter int           PTR_W      = 16,
   parameter int           LEN_W      = 16,
   parameter logic [15:0]  THRESH_RST = 16'h02F8,
   parameter bit           WIDE_EN    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wide_mode,
   input  logic               cfg_wr,
   input  logic [2:0]         cfg_sel,
   input  logic [PTR_W-1:0]   cfg_wdata,
   input  logic               fetch_req,
   input  logic               sts_clr,
   input  logic [15:0]        sts_clr_mask,
   input  logic               frame_valid,
   input  logic [LEN_W-1:0]   frame_len,
   output logic               frame_ready,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [2*PTR_W-1:0] mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [PTR_W-1:0]   mem_rsp_data,
   output logic [PTR_W-1:0]   rd_ptr,
   output logic [2*PTR_W-1:0] buf_addr,
   output logic [2*PTR_W-1:0] buf_words,
   output logic [15:0]        status,
   output logic               last_pkt,
   output logic               rx_stall,
   output logic               busy
);

   localparam int DBL_W = 2 * PTR_W;

   generate
      if (PTR_W < 8) begin : g_bad_ptr
         $error("PTR_W must be at least 8");
      end
      if (LEN_W < 4) begin : g_bad_len
         $error("LEN_W must be at least 4");
      end
   endgenerate

   logic                            wide;
   logic [PTR_W-1:0]                start_p, end_p, wr_p, upper_p, thresh;
   logic                            rd_load;
   logic [PTR_W-1:0]                rd_val;
   logic                            go, f_busy, f_done, f_exh;
   logic [ENTRY_WORDS-1:0][PTR_W-1:0] entry;
   logic                            frame_fire, exceed, need_next;
   logic                            pend_q, stall_q;
   logic [15:0]                     sts_q;
   logic                            clr_exh;
   logic                            rd_eq_wr;

   rx_rsrc_ring_cfg #(.PTR_W(PTR_W), .THRESH_RST(THRESH_RST), .WIDE_EN(WIDE_EN)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wide_i(wide_mode), .wr_en_i(cfg_wr), .sel_i(cfg_sel),
      .wdata_i(cfg_wdata), .wide_o(wide), .start_o(start_p), .end_o(end_p), .wrp_o(wr_p),
      .upper_o(upper_p), .thresh_o(thresh), .rd_load_o(rd_load), .rd_val_o(rd_val)
   );

   rx_rsrc_ring_fetch #(.PTR_W(PTR_W), .DATA_W(PTR_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .wide_i(wide), .start_i(start_p), .end_i(end_p),
      .wrp_i(wr_p), .upper_i(upper_p), .rd_load_i(rd_load), .rd_val_i(rd_val), .go_i(go),
      .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
      .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
      .mem_rsp_data_i(mem_rsp_data), .busy_o(f_busy), .done_o(f_done),
      .exhausted_o(f_exh), .rd_ptr_o(rd_ptr), .entry_o(entry)
   );

   rx_rsrc_ring_space #(.ADDR_W(DBL_W), .CNT_W(DBL_W), .LEN_W(LEN_W), .THR_W(PTR_W)) u_space (
      .clk(clk), .rst_n(rst_n), .wide_i(wide), .load_i(f_done),
      .load_addr_i({entry[1], entry[0]}), .load_cnt_i({entry[3], entry[2]}),
      .frame_fire_i(frame_fire), .frame_len_i(frame_len), .thresh_i(thresh),
      .buf_addr_o(buf_addr), .buf_words_o(buf_words), .last_pkt_o(last_pkt),
      .exceed_o(exceed), .need_next_o(need_next)
   );

   assign rd_eq_wr    = (rd_ptr == wr_p);
   assign frame_ready = !f_busy && !pend_q && !stall_q;
   assign frame_fire  = frame_valid && frame_ready;
   assign go          = pend_q && !f_busy;
   assign clr_exh     = sts_clr && sts_clr_mask[STS_EXHAUSTED] && sts_q[STS_EXHAUSTED];
   assign status      = sts_q;
   assign rx_stall    = stall_q;
   assign busy        = f_busy || pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q   <= '0;
         pend_q  <= 1'b0;
         stall_q <= 1'b0;
      end else begin
         sts_q <= (sts_q & ~(sts_clr ? sts_clr_mask : 16'h0000))
                  | (f_exh  ? (16'h0001 << STS_EXHAUSTED) : 16'h0000)
                  | (exceed ? (16'h0001 << STS_EXCEEDED)  : 16'h0000);
         pend_q <= (pend_q && !go) || fetch_req || clr_exh || (need_next && !rd_eq_wr);
         if (f_done)                    stall_q <= 1'b0;
         else if (need_next && rd_eq_wr) stall_q <= 1'b1;
      end
   end

   p_stall_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_stall) |-> $past(f_done));

   p_exhaust_on_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[STS_EXHAUSTED]) |-> $past(f_done));

   p_exceed_on_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[STS_EXCEEDED]) |-> $past(frame_valid));

endmodule

// File: tb/rx_rsrc_ring_tb.sv
module rx_rsrc_ring_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [15:0] cfg_wdata = 16'h0;
   logic        fetch_req = 1'b0;
   logic        sts_clr = 1'b0;
   logic [15:0] sts_clr_mask = 16'h0;
   logic        frame_valid = 1'b0;
   logic [15:0] frame_len = 16'h0;
   logic        frame_ready;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [15:0] mem_rsp_data = 16'h0;
   logic [15:0] rd_ptr;
   logic [31:0] buf_addr;
   logic [31:0] buf_words;
   logic [15:0] status;
   logic        last_pkt;
   logic        rx_stall;
   logic        busy;

   int n_chk = 0;
   int n_err = 0;
   int log_n = 0;
   logic [31:0] log_q [64];
   logic [15:0] mem [256];

   always #2 clk = ~clk;

   rx_rsrc_ring u_dut (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .fetch_req(fetch_req), .sts_clr(sts_clr),
      .sts_clr_mask(sts_clr_mask), .frame_valid(frame_valid), .frame_len(frame_len),
      .frame_ready(frame_ready), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rd_ptr(rd_ptr), .buf_addr(buf_addr), .buf_words(buf_words), .status(status),
      .last_pkt(last_pkt), .rx_stall(rx_stall), .busy(busy)
   );

   // memory model: ready toggles, response one cycle after acceptance
   always @(posedge clk) begin
      mem_req_ready <= ~mem_req_ready;
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= mem[mem_req_addr[8:1]];
      if (mem_req_valid && mem_req_ready) begin
         log_q[log_n % 64] <= mem_req_addr;
         log_n <= log_n + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [2:0] sel, input logic [15:0] val);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic put_entry(input int ptr, input bit wide, input logic [31:0] a, input logic [31:0] c);
      int sc;
      sc = wide ? 4 : 2;
      mem[((ptr + 0*sc) >> 1) % 256] = a[15:0];
      mem[((ptr + 1*sc) >> 1) % 256] = a[31:16];
      mem[((ptr + 2*sc) >> 1) % 256] = c[15:0];
      mem[((ptr + 3*sc) >> 1) % 256] = c[31:16];
   endtask

   task automatic wait_idle();
      int t;
      t = 0;
      @(negedge clk);
      while (busy && t < 500) begin
         @(negedge clk);
         t++;
      end
      if (busy) chk("R2 fetch completion", 32'd1, 32'd0);
   endtask

   task automatic do_fetch();
      @(negedge clk);
      fetch_req = 1'b1;
      @(negedge clk);
      fetch_req = 1'b0;
      wait_idle();
   endtask

   task automatic clear_sts(input logic [15:0] m);
      @(negedge clk);
      sts_clr = 1'b1; sts_clr_mask = m;
      @(negedge clk);
      sts_clr = 1'b0; sts_clr_mask = 16'h0;
   endtask

   task automatic send_frame(input logic [15:0] len);
      @(negedge clk);
      frame_valid = 1'b1; frame_len = len;
      @(negedge clk);
      frame_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 rd_ptr", {16'h0, rd_ptr}, 32'h0);
      chk("R1 buf_addr", buf_addr, 32'h0);
      chk("R1 buf_words", buf_words, 32'h0);
      chk("R1 status", {16'h0, status}, 32'h0);
      chk("R1 stall/last/req", {29'h0, rx_stall, last_pkt, mem_req_valid}, 32'h0);
      chk("R1 frame_ready", {31'h0, frame_ready}, 32'h1);
   endtask

   task automatic t_narrow_fetch();
      int base;
      cfg(3'd4, 16'h0003);
      cfg(3'd0, 16'h0040);
      cfg(3'd1, 16'h0060);
      cfg(3'd3, 16'h0058);
      cfg(3'd2, 16'h0040);
      put_entry(16'h40, 1'b0, 32'h1234_0100, 32'h0000_1000);
      base = log_n;
      do_fetch();
      chk("R2 request count", log_n - base, 4);
      for (int k = 0; k < 4; k++) chk("R2 request address", log_q[(base + k) % 64], 32'h0003_0040 + k*2);
      chk("R2 buffer address", buf_addr, 32'h1234_0100);
      chk("R2 word count", buf_words, 32'h0000_1000);
      chk("R3 advance narrow", {16'h0, rd_ptr}, 32'h48);
      chk("R4 no exhaustion", {16'h0, status}, 32'h0);
      send_frame(16'd61);
      chk("R7 words narrow", buf_words, 32'h1000 - 33);
      chk("R7 address narrow", buf_addr, 32'h1234_0100 + 66);
      chk("R7 last_pkt low", {31'h0, last_pkt}, 32'h0);
   endtask

   task automatic t_wrap_exhaust();
      cfg(3'd3, 16'h0048);
      cfg(3'd2, 16'h0058);
      put_entry(16'h58, 1'b0, 32'h9999_0000, 32'h0000_0020);
      do_fetch();
      chk("R3 wrap to start", {16'h0, rd_ptr}, 32'h40);
      chk("R4 wrap not exhausted", {16'h0, status}, 32'h0);
      chk("R2 wrap entry count", buf_words, 32'h20);
      do_fetch();
      chk("R4 exhausted set", {16'h0, status}, 32'h20);
      chk("R3 rd after", {16'h0, rd_ptr}, 32'h48);
   endtask

   task automatic t_stall();
      cfg(3'd5, 16'h0FFF);
      send_frame(16'd61);
      chk("R10 stall raised", {31'h0, rx_stall}, 32'h1);
      chk("R10 frame_ready low", {31'h0, frame_ready}, 32'h0);
      chk("R9 last_pkt below threshold", {31'h0, last_pkt}, 32'h1);
      chk("R9 words after frame", buf_words, 32'hFDF);
      send_frame(16'd61);
      chk("R10 frame ignored", buf_words, 32'hFDF);
      cfg(3'd3, 16'h0058);
      put_entry(16'h48, 1'b0, 32'h5555_0000, 32'h0000_0800);
      clear_sts(16'h0020);
      wait_idle();
      chk("R6 clear starts fetch", {16'h0, rd_ptr}, 32'h50);
      chk("R6 new count", buf_words, 32'h800);
      chk("R10 stall released", {31'h0, rx_stall}, 32'h0);
      chk("R10 frame_ready back", {31'h0, frame_ready}, 32'h1);
      chk("R4 status after refill", {16'h0, status}, 32'h0);
      cfg(3'd5, 16'h02F8);
   endtask

   task automatic t_clear_idle();
      int base;
      base = log_n;
      clear_sts(16'h0020);
      repeat (10) @(negedge clk);
      chk("R6 no fetch on clear bit", log_n - base, 0);
      chk("R6 rd unchanged", {16'h0, rd_ptr}, 32'h50);
   endtask

   task automatic t_exceed();
      cfg(3'd3, 16'h0048);
      put_entry(16'h50, 1'b0, 32'h7777_0000, 32'h0000_0010);
      put_entry(16'h58, 1'b0, 32'hAAAA_0000, 32'h0000_0400);
      do_fetch();
      chk("R3 rd to 0x58", {16'h0, rd_ptr}, 32'h58);
      send_frame(16'd40);
      chk("R8 exceeded bit", {16'h0, status}, 32'h10);
      chk("R8 last_pkt", {31'h0, last_pkt}, 32'h1);
      chk("R8 words unchanged", buf_words, 32'h10);
      chk("R8 address unchanged", buf_addr, 32'h7777_0000);
      wait_idle();
      chk("R9 next entry fetched", buf_words, 32'h400);
      chk("R3 wrap after auto fetch", {16'h0, rd_ptr}, 32'h40);
      clear_sts(16'h0010);
      chk("R8 exceeded cleared", {16'h0, status}, 32'h0);
   endtask

   task automatic t_threshold();
      send_frame(16'h020E);
      chk("R9 last_pkt at threshold", {31'h0, last_pkt}, 32'h1);
      chk("R9 words below", buf_words, 32'h2F7);
      chk("R8 no exceed", {16'h0, status}, 32'h0);
      wait_idle();
      chk("R9 auto fetch rd", {16'h0, rd_ptr}, 32'h48);
      chk("R9 auto fetch count", buf_words, 32'h1000);
      send_frame(16'd10);
      chk("R9 last_pkt cleared", {31'h0, last_pkt}, 32'h0);
      chk("R7 small frame", buf_words, 32'hFF9);
   endtask

   task automatic t_mask();
      cfg(3'd2, 16'h0047);
      chk("R5 narrow mask", {16'h0, rd_ptr}, 32'h46);
      wide_mode = 1'b1;
      cfg(3'd2, 16'h0047);
      chk("R5 wide mask", {16'h0, rd_ptr}, 32'h44);
   endtask

   task automatic t_wide();
      int base;
      cfg(3'd0, 16'h0100);
      cfg(3'd1, 16'h0120);
      cfg(3'd3, 16'h0104);
      cfg(3'd2, 16'h0100);
      put_entry(16'h100, 1'b1, 32'h0BAD_0000, 32'h0000_2000);
      put_entry(16'h110, 1'b1, 32'h0C00_0000, 32'h0000_3000);
      base = log_n;
      do_fetch();
      for (int k = 0; k < 4; k++) chk("R2 wide address", log_q[(base + k) % 64], 32'h0003_0100 + k*4);
      chk("R3 wide advance", {16'h0, rd_ptr}, 32'h110);
      chk("R2 wide count", buf_words, 32'h2000);
      send_frame(16'd61);
      chk("R7 words wide", buf_words, 32'h2000 - 34);
      chk("R7 address wide", buf_addr, 32'h0BAD_0000 + 68);
      do_fetch();
      chk("R3 wide wrap", {16'h0, rd_ptr}, 32'h100);
      chk("R2 wide second count", buf_words, 32'h3000);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_narrow_fetch();
      t_wrap_exhaust();
      t_stall();
      t_clear_idle();
      t_exceed();
      t_threshold();
      t_mask();
      t_wide();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog: actual=0x%0h expected=0x%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule